// File: doc/BRIEF.md
# Power-Down Request Qualification Timer

This block decides when a function's request to enter power down has lasted long enough to be worth an interrupt. A 3-bit filter code selects the behaviour: off, one of three fixed waits measured in seconds, or an immediate response. An internal prescaler divides the system clock into one-second ticks, and a second counter measures the wait. The interrupt is raised only if the request is still present when the wait ends. A request that drops part way through abandons the wait. A change of code during a wait starts the count again under the new setting.

Once raised, the interrupt is sticky. It stays high until the request goes away or software pulses a clear. After a clear it does not fire again until the request has first been seen low. All pins are plain control and status levels. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `pwrdn_qual_timer`

## Requirements
- R1: With `filt_code` = 3'b000, `pd_irq` is never asserted. Changing the code to 3'b000 during a wait abandons that wait without an interrupt.
- R2: Codes 3'b001, 3'b010 and 3'b011 select waits of 4, 129 and 518 seconds, where one second is `CYC_PER_SEC` clock cycles. With the request held high, `pd_irq` first reads 1 after exactly T*CYC_PER_SEC+1 rising edges, counted from the first edge that samples the request high. After one edge fewer it still reads 0.
- R3: Any code with bit 2 set (3'b1xx) makes `pd_irq` read 1 after the first rising edge that samples the request high.
- R4: If `pd_req` is sampled low during a wait, the wait is discarded. A later request must then wait the full time again.
- R5: A change of `filt_code` between nonzero waiting codes restarts the wait. The new full time is counted from the edge that samples the change.
- R6: While the request stays high and no clear arrives, `pd_irq` stays at 1. It returns to 0 after the first edge that samples `pd_req` low.
- R7: A one-cycle `irq_clr` pulse while `pd_irq` is high drops it after that edge. It stays low while the request remains high, and it can fire again only after `pd_req` has been sampled low.
- R8: While `rst_n` is low, and just after reset with no request, `pd_irq` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| filt_code | input | 3 | Filter selection code (000 off, 001/010/011 waits, 1xx immediate) |
| pd_req | input | 1 | Power-down request level from the function |
| irq_clr | input | 1 | Single-cycle clear of a raised interrupt |
| pd_irq | output | 1 | Qualified power-down interrupt, sticky |

## Verification
A wrong prescaler or second-counter value moves the edge on which `pd_irq` rises. The bench probes each waiting code one edge before and exactly at the expected edge, so an off-by-one shows up within a single cycle of the four-second point. A missed restart or abandoned wait shows up as an interrupt that arrives too early after a request drop or a code change. A wrong controller state shows up within one edge, because the immediate, release and clear paths each have a fixed one-edge response.

// File: rtl/pqt_pkg.sv
package pqt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE         = 2'd0,
    ST_COUNTING     = 2'd1,
    ST_ASSERTED     = 2'd2,
    ST_WAIT_RELEASE = 2'd3
  } pqt_state_e;

  localparam int CODE_W = 3;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pqt_prescale.sv
module pqt_prescale #(
  parameter int CYC_PER_SEC = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (CYC_PER_SEC > 1) ? $clog2(CYC_PER_SEC) : 1;

  generate
    if (CYC_PER_SEC == 1) begin : g_every
      assign tick = !clr;
    end else begin : g_div
      logic [CW-1:0] cnt_q;
      localparam logic [CW-1:0] LAST = CW'(CYC_PER_SEC - 1);

      always_ff @(posedge clk) begin
        if (!rst_n || clr)       cnt_q <= '0;
        else if (cnt_q == LAST)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
      end

      assign tick = !clr && (cnt_q == LAST);

      // R2: the cycle counter never leaves its one-second range
      p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
      // R5: a clear restarts the second from zero
      p_clr_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0);
    end
  endgenerate
endmodule

// File: rtl/pqt_delay_lut.sv
module pqt_delay_lut #(
  parameter int SEC_SHORT = 4,
  parameter int SEC_MID   = 129,
  parameter int SEC_LONG  = 518,
  parameter int SW        = 10
) (
  input  logic [2:0]    code,
  output logic          enable,
  output logic          immediate,
  output logic [SW-1:0] target
);
  always_comb begin
    enable    = 1'b1;
    immediate = 1'b0;
    target    = SW'(1);
    if (code[2]) begin
      immediate = 1'b1;
    end else begin
      case (code[1:0])
        2'b01:   target = SW'(SEC_SHORT);
        2'b10:   target = SW'(SEC_MID);
        2'b11:   target = SW'(SEC_LONG);
        default: enable = 1'b0;
      endcase
    end
  end

  // R1: the off code never enables the filter
  always_comb begin
    a_off_r1: assert (!(code == 3'b000 && enable));
  end
endmodule

// File: rtl/pqt_sec_count.sv
module pqt_sec_count #(
  parameter int SW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [SW-1:0] target,
  output logic          expire
);
  logic [SW-1:0] sec_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) sec_q <= '0;
    else if (tick)     sec_q <= sec_q + 1'b1;
  end

  assign expire = tick && (sec_q == target - SW'(1));

  // R2: seconds counted never reach the target while counting
  p_sec_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && target != '0) |-> sec_q < target);
  // R4: a clear discards the elapsed seconds
  p_sec_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> sec_q == '0);
endmodule

// File: rtl/pqt_ctrl.sv
module pqt_ctrl
  import pqt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] code,
  input  logic       pd_req,
  input  logic       irq_clr,
  input  logic       enable,
  input  logic       immediate,
  input  logic       expire,
  output logic       cnt_clr,
  output logic       pd_irq
);
  pqt_state_e state_q, state_d;
  logic [2:0] code_q;
  logic       changed;

  assign changed = (code != code_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      code_q  <= '0;
    end else begin
      state_q <= state_d;
      code_q  <= code;
    end
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (pd_req && enable) state_d = immediate ? ST_ASSERTED : ST_COUNTING;
      end
      ST_COUNTING: begin
        if (!pd_req || !enable) state_d = ST_IDLE;
        else if (immediate)     state_d = ST_ASSERTED;
        else if (changed)       state_d = ST_COUNTING;
        else if (expire)        state_d = ST_ASSERTED;
      end
      ST_ASSERTED: begin
        if (!pd_req)      state_d = ST_IDLE;
        else if (irq_clr) state_d = ST_WAIT_RELEASE;
      end
      ST_WAIT_RELEASE: begin
        if (!pd_req) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign cnt_clr = (state_q != ST_COUNTING) || changed;
  assign pd_irq  = (state_q == ST_ASSERTED);

  // R1: an interrupt never rises under the off code
  p_off_never_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_irq) |-> $past(code) != 3'b000);
  // R3: immediate code answers on the first edge
  p_immediate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && pd_req && code[2]) |=> pd_irq);
  // R6: request loss always drops the interrupt
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_req |=> !pd_irq);
  // R7: a clear drops a raised interrupt
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_irq && irq_clr) |=> !pd_irq);
  // R7: no re-arm before the request is seen low
  p_norearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT_RELEASE) |=> !pd_irq);
endmodule

// File: rtl/pwrdn_qual_timer.sv
module pwrdn_qual_timer #(
  parameter int CYC_PER_SEC = 50_000_000,
  parameter int SEC_SHORT   = 4,
  parameter int SEC_MID     = 129,
  parameter int SEC_LONG    = 518
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] filt_code,
  input  logic       pd_req,
  input  logic       irq_clr,
  output logic       pd_irq
);
  localparam int SEC_MAX = pqt_pkg::max3(SEC_SHORT, SEC_MID, SEC_LONG);
  localparam int SW      = $clog2(SEC_MAX + 1);

  logic          tick, cnt_clr, expire, enable, immediate;
  logic [SW-1:0] target;

  pqt_prescale #(.CYC_PER_SEC(CYC_PER_SEC)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .tick(tick)
  );

  pqt_delay_lut #(
    .SEC_SHORT(SEC_SHORT), .SEC_MID(SEC_MID), .SEC_LONG(SEC_LONG), .SW(SW)
  ) u_lut (
    .code(filt_code), .enable(enable), .immediate(immediate), .target(target)
  );

  pqt_sec_count #(.SW(SW)) u_sec (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .tick(tick),
    .target(target), .expire(expire)
  );

  pqt_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .code(filt_code), .pd_req(pd_req),
    .irq_clr(irq_clr), .enable(enable), .immediate(immediate),
    .expire(expire), .cnt_clr(cnt_clr), .pd_irq(pd_irq)
  );

  // R8: reset leaves the interrupt low
  p_reset_low_r8: assert property (@(posedge clk)
    !rst_n |=> !pd_irq);
endmodule

// File: tb/sim_pwrdn_qual_timer.sv
`timescale 1ns/1ps
module sim_pwrdn_qual_timer;
  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] filt_code = 3'b000;
  logic       pd_req = 1'b0;
  logic       irq_clr = 1'b0;
  logic       pd_irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwrdn_qual_timer #(.CYC_PER_SEC(N)) u0 (
    .clk(clk), .rst_n(rst_n), .filt_code(filt_code), .pd_req(pd_req),
    .irq_clr(irq_clr), .pd_irq(pd_irq)
  );

  // {code, edges held, expected pd_irq}
  localparam int NV = 13;
  localparam logic [19:0] VEC [NV] = '{
    {3'd0, 16'(10*N),      1'b0},
    {3'd1, 16'(4*N),       1'b0},
    {3'd1, 16'(4*N+1),     1'b1},
    {3'd2, 16'(129*N),     1'b0},
    {3'd2, 16'(129*N+1),   1'b1},
    {3'd3, 16'(518*N),     1'b0},
    {3'd3, 16'(518*N+1),   1'b1},
    {3'd4, 16'd1,          1'b1},
    {3'd7, 16'd1,          1'b1},
    {3'd6, 16'd0,          1'b0},
    {3'd5, 16'd20,         1'b1},
    {3'd1, 16'(4*N+30),    1'b1},
    {3'd0, 16'd1,          1'b0}
  };

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s pd_irq=%0b expected=%0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic wait_edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    wait_edges(3);
    check("R8 in reset", pd_irq, 1'b0);
    rst_n = 1'b1;
    wait_edges(2);
    check("R8 after reset", pd_irq, 1'b0);

    // vector table: R1 R2 R3 R6
    for (int v = 0; v < NV; v++) begin
      filt_code = VEC[v][19:17];
      pd_req = 1'b1;
      wait_edges(int'(VEC[v][16:1]));
      check($sformatf("R1/R2/R3 vector %0d", v), pd_irq, VEC[v][0]);
      pd_req = 1'b0;
      wait_edges(1);
      check($sformatf("R6 release vector %0d", v), pd_irq, 1'b0);
      wait_edges(1);
    end

    // R4: drop part way discards the wait
    filt_code = 3'd1; pd_req = 1'b1;
    wait_edges(3*N);
    pd_req = 1'b0; wait_edges(1);
    pd_req = 1'b1;
    wait_edges(4*N);
    check("R4 no early irq after drop", pd_irq, 1'b0);
    wait_edges(1);
    check("R4 full wait after drop", pd_irq, 1'b1);
    pd_req = 1'b0; wait_edges(2);

    // R5: code change restarts with the new time
    filt_code = 3'd2; pd_req = 1'b1;
    wait_edges(3*N);
    filt_code = 3'd1;
    wait_edges(4*N);
    check("R5 restart not yet expired", pd_irq, 1'b0);
    wait_edges(1);
    check("R5 restart expired", pd_irq, 1'b1);
    pd_req = 1'b0; wait_edges(2);

    // R1: switching to off mid-wait abandons it
    filt_code = 3'd1; pd_req = 1'b1;
    wait_edges(2*N);
    filt_code = 3'd0;
    wait_edges(6*N);
    check("R1 off mid-wait", pd_irq, 1'b0);
    pd_req = 1'b0; wait_edges(2);

    // R7: clear and no re-arm
    filt_code = 3'd5; pd_req = 1'b1;
    wait_edges(1);
    check("R7 immediate raise", pd_irq, 1'b1);
    irq_clr = 1'b1; wait_edges(1); irq_clr = 1'b0;
    check("R7 cleared", pd_irq, 1'b0);
    wait_edges(8);
    check("R7 no re-arm while held", pd_irq, 1'b0);
    pd_req = 1'b0; wait_edges(1);
    pd_req = 1'b1; wait_edges(1);
    check("R7 re-arm after release", pd_irq, 1'b1);
    pd_req = 1'b0; wait_edges(2);

    // R8: reset mid-assert
    pd_req = 1'b1; wait_edges(1);
    rst_n = 1'b0; wait_edges(1);
    check("R8 reset drops irq", pd_irq, 1'b0);
    pd_req = 1'b0; rst_n = 1'b1; wait_edges(2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule